// File: doc/BRIEF.md
# Memory Readback Integrity Guard

This block sits between a single requester and a synchronous memory port with one cycle of read latency. When its check is turned on, every access the requester makes is followed one cycle later by a second read of the same address. The second read's data is compared against what the location should hold. For a write, that is the data just written. For a read, it is the data that the first access returned. A mismatch means the memory can no longer be trusted. The block then latches a terminal error, pulses a fatal alert, and refuses every later request until reset.

The check is switched by a 4-bit multibit enable. Only the code 0x9 means off, and every other pattern means on, so a single flipped bit can never silently disable the protection. A lock bit guards the enable. The lock starts at 1 and is cleared by writing 0. Once cleared, the enable is frozen until reset. While the check is on, each access costs the requester one stall cycle, because the memory port is taken by the readback.

Top module: `mem_readback_guard`

## Requirements
- R1: After reset the enable reads 0x9, the lock reads 1, `err_o` and `alert_o` are 0 and `req_ready_o` is 1.
- R2: A configuration write with `cfg_sel_i`=0 while the lock is 1 loads `cfg_wdata_i` into the enable. The value 0x9 turns the check off, and any other 4-bit value turns it on.
- R3: A configuration write with `cfg_sel_i`=1 clears the lock when `cfg_wdata_i[0]` is 0 and has no effect when it is 1. While the lock is 0, writes to the enable are ignored and the lock stays 0 until reset.
- R4: When the check is on, an accepted request (`req_valid_i` and `req_ready_o` both 1) is followed in the next cycle by a memory read (`mem_req_o`=1, `mem_we_o`=0) of the same address, with `req_ready_o` at 0 in that cycle only.
- R5: A read accepted in cycle t produces `rsp_valid_o`=1 in cycle t+1, with `rsp_rdata_o` carrying the memory's data for that first access.
- R6: The readback data is compared with the write data for a write, or with the first returned data for a read, in the cycle after the readback. A mismatch sets `err_o` at the next edge, and `err_o` then stays 1 until reset.
- R7: `alert_o` is high for exactly one cycle, the first cycle in which `err_o` is 1.
- R8: While `err_o` is 1, `req_ready_o` is 0 and no new memory access is started.
- R9: When the check is off, accesses pass straight through with no stall and no readback, and corrupted memory never sets `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | Configuration target: 0 enable, 1 lock |
| cfg_wdata_i | input | 4 | Configuration write data |
| cfg_en_o | output | 4 | Current enable code |
| cfg_unlocked_o | output | 1 | Lock bit, 1 while the enable is writable |
| req_valid_i | input | 1 | Requester access valid |
| req_write_i | input | 1 | Requester access is a write |
| req_addr_i | input | AW | Requester address |
| req_wdata_i | input | DW | Requester write data |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | DW | Read data |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data, one cycle after the strobe |
| err_o | output | 1 | Terminal readback error |
| alert_o | output | 1 | One-cycle fatal alert |

## Verification
The hardest situation to reach is a real readback mismatch, because a healthy memory always returns what was written. The bench's memory model can be set to drop writes. A write of a value that differs from the stored one then makes the readback return stale data. The same fault is first applied with the check off, which shows it is ignored. Before the error is triggered, back-to-back requests are issued so that a new access is accepted in the compare cycle of the previous one. The lock is also cleared, so that the frozen enable is observed before the terminal error.

// File: rtl/mem_readback_guard.sv
module mem_readback_guard #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic          cfg_sel_i,
  input  logic [3:0]    cfg_wdata_i,
  output logic [3:0]    cfg_en_o,
  output logic          cfg_unlocked_o,
  input  logic          req_valid_i,
  input  logic          req_write_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          req_ready_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          err_o,
  output logic          alert_o
);
  localparam logic [3:0] MbFalse = 4'h9;

  typedef enum logic [1:0] {Idle, Readback, Compare} phase_e;

  phase_e        phase_q;
  logic [3:0]    en_q;
  logic          unlocked_q;
  logic          err_q, alert_q, rd_pend_q, wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] exp_q;

  logic check_on, accept, mismatch;

  assign check_on = en_q != MbFalse;
  assign req_ready_o = (phase_q != Readback) && !err_q;
  assign accept = req_valid_i && req_ready_o;
  assign mismatch = (phase_q == Compare) && (mem_rdata_i != exp_q);

  assign mem_req_o   = accept || (phase_q == Readback);
  assign mem_we_o    = accept && req_write_i;
  assign mem_addr_o  = (phase_q == Readback) ? addr_q : req_addr_i;
  assign mem_wdata_o = req_wdata_i;

  assign rsp_valid_o    = rd_pend_q;
  assign rsp_rdata_o    = mem_rdata_i;
  assign cfg_en_o       = en_q;
  assign cfg_unlocked_o = unlocked_q;
  assign err_o          = err_q;
  assign alert_o        = alert_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= MbFalse;
      unlocked_q <= 1'b1;
    end else if (cfg_we_i) begin
      if (!cfg_sel_i && unlocked_q) en_q <= cfg_wdata_i;
      if (cfg_sel_i && !cfg_wdata_i[0]) unlocked_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= Idle;
    end else if (accept && check_on) begin
      phase_q <= Readback;
    end else if (phase_q == Readback) begin
      phase_q <= Compare;
    end else begin
      phase_q <= Idle;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      wr_q   <= 1'b0;
      exp_q  <= '0;
    end else if (accept) begin
      addr_q <= req_addr_i;
      wr_q   <= req_write_i;
      exp_q  <= req_wdata_i;
    end else if (phase_q == Readback && !wr_q) begin
      exp_q  <= mem_rdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q     <= 1'b0;
      alert_q   <= 1'b0;
      rd_pend_q <= 1'b0;
    end else begin
      err_q     <= err_q || mismatch;
      alert_q   <= mismatch && !err_q;
      rd_pend_q <= accept && !req_write_i;
    end
  end
endmodule

module mem_readback_guard_chk #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [3:0]    cfg_en_o,
  input logic          cfg_unlocked_o,
  input logic          req_valid_i,
  input logic          req_write_i,
  input logic [AW-1:0] req_addr_i,
  input logic          req_ready_o,
  input logic          rsp_valid_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          err_o,
  input logic          alert_o
);
  logic acc_on;
  assign acc_on = req_valid_i && req_ready_o && (cfg_en_o != 4'h9);

  assert_readback_issued_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_on |=> (mem_req_o && !mem_we_o && mem_addr_o == $past(req_addr_i) && !req_ready_o));

  assert_read_response_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !req_write_i) |=> rsp_valid_o);

  assert_error_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  assert_alert_on_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_o |-> (err_o && !$past(err_o)));

  assert_alert_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> alert_o);

  assert_blocked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !req_ready_o);

  assert_lock_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_unlocked_o |=> (!cfg_unlocked_o && $stable(cfg_en_o)));
endmodule

bind mem_readback_guard mem_readback_guard_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_en_o(cfg_en_o), .cfg_unlocked_o(cfg_unlocked_o),
  .req_valid_i(req_valid_i), .req_write_i(req_write_i), .req_addr_i(req_addr_i),
  .req_ready_o(req_ready_o), .rsp_valid_o(rsp_valid_o), .mem_req_o(mem_req_o),
  .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .err_o(err_o), .alert_o(alert_o)
);

// File: tb/mem_readback_guard_tb.sv
`timescale 1ns/1ps
module mem_readback_guard_tb_top;
  localparam int AW = 6;
  localparam int DW = 16;

  logic clk = 0, rst_ni = 0;
  always #2 clk = ~clk;

  logic cfg_we = 0, cfg_sel = 0;
  logic [3:0] cfg_wdata = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = 0;
  logic [DW-1:0] req_wdata = 0;
  logic [3:0] cfg_en;
  logic cfg_unlocked, req_ready, rsp_valid, mem_req, mem_we, err, alert;
  logic [DW-1:0] rsp_rdata, mem_wdata, mem_rd_q;
  logic [AW-1:0] mem_addr;

  mem_readback_guard #(.AW(AW), .DW(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .cfg_en_o(cfg_en), .cfg_unlocked_o(cfg_unlocked),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_ready_o(req_ready), .rsp_valid_o(rsp_valid),
    .rsp_rdata_o(rsp_rdata), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rd_q),
    .err_o(err), .alert_o(alert)
  );

  int checks = 0, fails = 0;
  logic drop = 0;
  logic [DW-1:0] mem [64];

  initial for (int i = 0; i < 64; i++) mem[i] = DW'(i * 16'h0111);

  always @(posedge clk) begin
    if (mem_req && !mem_we) mem_rd_q <= mem[mem_addr];
    if (mem_req && mem_we && !drop) mem[mem_addr] <= mem_wdata;
  end

  int m_phase;
  logic m_err, m_alert, m_lock, m_rdpend, m_bad;
  logic [3:0] m_en;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_rddata;
  logic m_ready, m_acc;
  assign m_ready = (m_phase != 1) && !m_err;
  assign m_acc = req_valid && m_ready;

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_phase <= 0; m_err <= 0; m_alert <= 0; m_en <= 4'h9; m_lock <= 1;
      m_rdpend <= 0; m_bad <= 0; m_addr <= '0; m_rddata <= '0;
    end else begin
      m_rdpend <= m_acc && !req_write;
      if (m_acc) begin
        m_rddata <= mem[req_addr];
        m_addr <= req_addr;
        m_bad <= (m_en != 4'h9) && req_write && drop && (mem[req_addr] != req_wdata);
      end
      if (m_acc && m_en != 4'h9) m_phase <= 1;
      else if (m_phase == 1) m_phase <= 2;
      else m_phase <= 0;
      m_alert <= (m_phase == 2) && m_bad && !m_err;
      if (m_phase == 2 && m_bad) m_err <= 1;
      if (cfg_we && !cfg_sel && m_lock) m_en <= cfg_wdata;
      if (cfg_we && cfg_sel && !cfg_wdata[0]) m_lock <= 0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_ni) begin
    check("R4 ready", 32'(req_ready), 32'(m_ready));
    check("R8 mem_req", 32'(mem_req), 32'(m_acc || m_phase == 1));
    check("R5 rsp_valid", 32'(rsp_valid), 32'(m_rdpend));
    if (m_rdpend) check("R5 rsp_rdata", 32'(rsp_rdata), 32'(m_rddata));
    check("R6 err", 32'(err), 32'(m_err));
    check("R7 alert", 32'(alert), 32'(m_alert));
    check("R2 enable", 32'(cfg_en), 32'(m_en));
    check("R3 lock", 32'(cfg_unlocked), 32'(m_lock));
    if (m_phase == 1) begin
      check("R4 rb_addr", 32'(mem_addr), 32'(m_addr));
      check("R4 rb_read", 32'(mem_we), 32'd0);
    end
  end

  task automatic cfg(input logic sel, input logic [3:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic access(input logic wr, input int a, input logic [DW-1:0] d);
    req_valid = 1; req_write = wr; req_addr = AW'(a); req_wdata = d;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    @(negedge clk);
    check("R1 enable", 32'(cfg_en), 32'h9);
    check("R1 lock", 32'(cfg_unlocked), 32'd1);
    check("R1 err", 32'(err), 32'd0);
    check("R1 alert", 32'(alert), 32'd0);
    check("R1 ready", 32'(req_ready), 32'd1);
    @(posedge clk); #1;
    // R9: check off, dropped writes go unnoticed
    access(1, 3, 16'hAAAA); access(0, 3, 0);
    drop = 1;
    access(1, 4, 16'h1234); access(0, 4, 0);
    idle(3); drop = 0;
    check("R9 no_err_when_off", 32'(err), 32'd0);
    // R2: true code and arbitrary codes enable
    cfg(0, 4'h6);
    access(1, 5, 16'h5555); access(0, 5, 0); access(0, 6, 0); access(1, 7, 16'h7777);
    idle(3);
    cfg(0, 4'h0);
    access(1, 8, 16'h0808); access(0, 8, 0);
    idle(3);
    cfg(0, 4'h9);
    access(1, 9, 16'h0909); access(0, 9, 0);
    idle(2);
    cfg(0, 4'hC);
    access(0, 10, 0);
    idle(3);
    // R3: writing 1 keeps lock, writing 0 clears it, enable then frozen
    cfg(1, 4'h1);
    check("R3 lock_kept", 32'(cfg_unlocked), 32'd1);
    cfg(1, 4'h0);
    cfg(0, 4'h9);
    check("R3 enable_frozen", 32'(cfg_en), 32'hC);
    access(1, 11, 16'h0B0B); access(0, 11, 0);
    idle(3);
    // R6 R7 R8: dropped write while check on
    drop = 1;
    access(1, 12, 16'hBEEF);
    idle(4);
    check("R6 err_set", 32'(err), 32'd1);
    access(0, 13, 0);
    idle(5);
    check("R8 blocked", 32'(req_ready), 32'd0);
    check("R6 err_sticky", 32'(err), 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule